// File: doc/BRIEF.md
# Four-Way Pairwise-Age Replacement Controller

This block keeps the replacement state of a four-way set-associative cache and names the way to evict when a lookup misses. Each set owns a 6-bit vector. Every bit compares the ages of one pair of ways, so the six bits together hold a full age ordering of the four ways. When a cache hit or a miss fill touches a way, that way becomes the newest in its set. The victim way is decoded combinationally from the vector of the set being read.

Software can read the vector of any set through the read port and overwrite it through a write port. A power-on reset brings every set back to its initial ordering. A manual reset and standby only freeze the state, so the recorded ages survive both.

Top module: `lru4_repl_ctrl`

## Requirements
- R1: While `por_n` is low, every set vector is 6'b000000. That vector decodes to victim way 3 with `victim_err` low.
- R2: Bit meaning (bit: pair): 5: ways 0/1, 4: ways 0/2, 3: ways 0/3, 2: ways 1/2, 1: ways 1/3, 0: ways 2/3. A 1 means the lower-numbered way of the pair is the older one. For each of the 24 vectors that describe a consistent ordering, the victim is the oldest way and `victim_err` is 0. In particular the victim is way 0 when bits 5,4,3 are 111, way 1 when bit 5 is 0 and bits 2,1 are 11, way 2 when bits 4,2 are 00 and bit 0 is 1, and way 3 when bits 3,1,0 are 000.
- R3: An accepted access (`acc_vld` high) to way W of set S makes W the newest way of S from the next clock edge on. Only the three bits that pair W with another way change.
- R4: Using only hardware accesses from power-on reset, the victim of every set is the way of that set that was accessed least recently.
- R5: An accepted software write stores `sw_wdata` into set `sw_set` at the next clock edge. `rd_vec` shows the vector of set `rd_set` combinationally.
- R6: If a software write and an access address the same set in the same cycle, the software value is stored. If they address different sets, both take effect.
- R7: A vector that describes no consistent ordering (40 of the 64 values) decodes to victim way 0 with `victim_err` high.
- R8: While `mrst_n` is low or `stby` is high, accesses and software writes are ignored and every vector keeps its value. Neither a manual reset nor standby clears any vector.
- R9: Hardware accesses never turn a consistent vector into an inconsistent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all vectors |
| mrst_n | input | 1 | Manual reset, active low; blocks updates, keeps vectors |
| stby | input | 1 | Standby; blocks updates, keeps vectors |
| acc_vld | input | 1 | Access strobe (hit or miss fill) |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way touched by the access |
| sw_we | input | 1 | Software write strobe |
| sw_set | input | SET_W | Set index of the software write |
| sw_wdata | input | 6 | Vector value to store |
| rd_set | input | SET_W | Set whose vector and victim are shown |
| rd_vec | output | 6 | Stored vector of `rd_set` |
| victim_way | output | 2 | Way to replace in `rd_set` |
| victim_err | output | 1 | Vector of `rd_set` is not a consistent ordering |

## Verification
The bench tracks an age list for every set and goes after the cases where a careless design goes wrong. An update that flips the wrong pair bit would let a later miss evict a recently used way. A decoder that only checks the three bits of one way would accept some cyclic patterns as legal, so every one of the 64 codes is written and decoded. A write and an access that collide on one set would leave the hardware update in place if priority were reversed. A manual reset or standby that is treated as a clear would reset the ordering to its initial state, where the victim becomes way 3 again.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
   localparam int WAY_N  = 4;
   localparam int PAIR_N = 6;

   typedef logic [PAIR_N-1:0] age_vec_t;
   typedef logic [1:0]        way_t;

   // lower-numbered way of the pair held in bit k
   function automatic int pair_lo(int k);
      case (k)
         5, 4, 3: return 0;
         2, 1:    return 1;
         default: return 2;
      endcase
   endfunction

   // higher-numbered way of the pair held in bit k
   function automatic int pair_hi(int k);
      case (k)
         5:       return 1;
         4, 2:    return 2;
         default: return 3;
      endcase
   endfunction

   // true when every pair bit involving w says w is newer
   function automatic logic is_newest(age_vec_t v, way_t w);
      for (int k = 0; k < PAIR_N; k++) begin
         if (pair_lo(k) == int'(w) && v[k])  return 1'b0;
         if (pair_hi(k) == int'(w) && !v[k]) return 1'b0;
      end
      return 1'b1;
   endfunction

   // true when every pair bit involving w says w is older
   function automatic logic is_oldest(age_vec_t v, way_t w);
      for (int k = 0; k < PAIR_N; k++) begin
         if (pair_lo(k) == int'(w) && !v[k]) return 1'b0;
         if (pair_hi(k) == int'(w) && v[k])  return 1'b0;
      end
      return 1'b1;
   endfunction

   // consistency by the absence of cyclic triangles
   function automatic logic is_consistent(age_vec_t v);
      logic c012, c013, c023, c123;
      c012 = (v[5] & v[2] & ~v[4]) | (~v[5] & ~v[2] & v[4]);
      c013 = (v[5] & v[1] & ~v[3]) | (~v[5] & ~v[1] & v[3]);
      c023 = (v[4] & v[0] & ~v[3]) | (~v[4] & ~v[0] & v[3]);
      c123 = (v[2] & v[0] & ~v[1]) | (~v[2] & ~v[0] & v[1]);
      return !(c012 | c013 | c023 | c123);
   endfunction
endpackage

// File: rtl/lru4_update.sv
module lru4_update
   import lru4_pkg::*;
(
   input  age_vec_t cur_vec,
   input  way_t     hit_way,
   output age_vec_t nxt_vec
);
   for (genvar k = 0; k < PAIR_N; k++) begin : g_pair
      localparam int LO = pair_lo(k);
      localparam int HI = pair_hi(k);
      // touched lower way -> it is no longer older; touched upper way -> lower is older
      assign nxt_vec[k] = (hit_way == way_t'(LO)) ? 1'b0 :
                          (hit_way == way_t'(HI)) ? 1'b1 : cur_vec[k];
   end
endmodule

// File: rtl/lru4_victim_dec.sv
module lru4_victim_dec
   import lru4_pkg::*;
(
   input  age_vec_t vec,
   output way_t     victim,
   output logic     illegal
);
   logic [WAY_N-1:0][1:0] wins;

   function automatic logic [1:0] win_count(age_vec_t v, int w);
      logic [1:0] n;
      n = '0;
      for (int k = 0; k < PAIR_N; k++) begin
         if (pair_lo(k) == w) n = n + {1'b0, v[k]};
         if (pair_hi(k) == w) n = n + {1'b0, ~v[k]};
      end
      return n;
   endfunction

   for (genvar w = 0; w < WAY_N; w++) begin : g_way
      assign wins[w] = win_count(vec, w);
   end

   always_comb begin
      logic [WAY_N-1:0] rank_seen;
      logic             dup;
      rank_seen = '0;
      dup       = 1'b0;
      victim    = '0;
      for (int w = 0; w < WAY_N; w++) begin
         if (rank_seen[wins[w]]) dup = 1'b1;
         rank_seen[wins[w]] = 1'b1;
      end
      illegal = dup;
      if (!dup) begin
         for (int w = 0; w < WAY_N; w++)
            if (wins[w] == 2'd3) victim = way_t'(w);
      end
   end
endmodule

// File: rtl/lru4_set_array.sv
module lru4_set_array
   import lru4_pkg::*;
#(
   parameter int NUM_SETS = 16
)(
   input  logic                      clk,
   input  logic                      por_n,
   input  logic     [NUM_SETS-1:0]   wr_en,
   input  age_vec_t [NUM_SETS-1:0]   wr_data,
   output age_vec_t [NUM_SETS-1:0]   q
);
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      age_vec_t r_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)        r_q <= '0;
         else if (wr_en[s]) r_q <= wr_data[s];
      end
      assign q[s] = r_q;
   end
endmodule

// File: rtl/lru4_repl_ctrl.sv
module lru4_repl_ctrl
   import lru4_pkg::*;
#(
   parameter  int NUM_SETS = 16,
   localparam int SET_W    = $clog2(NUM_SETS)
)(
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             stby,
   input  logic             acc_vld,
   input  logic [SET_W-1:0] acc_set,
   input  logic [1:0]       acc_way,
   input  logic             sw_we,
   input  logic [SET_W-1:0] sw_set,
   input  logic [5:0]       sw_wdata,
   input  logic [SET_W-1:0] rd_set,
   output logic [5:0]       rd_vec,
   output logic [1:0]       victim_way,
   output logic             victim_err
);
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (WAY_N != 4 || PAIR_N != 6) begin : g_bad_ways
      $error("pair encoding is defined for four ways only");
   end

   logic                    upd_open, acc_go, sw_go;
   age_vec_t [NUM_SETS-1:0] cur_q, nxt_d;
   logic     [NUM_SETS-1:0] wen;
   age_vec_t                acc_cur, acc_nxt;

   assign upd_open = mrst_n && !stby;
   assign acc_go   = acc_vld && upd_open;
   assign sw_go    = sw_we && upd_open;
   assign acc_cur  = cur_q[acc_set];

   lru4_update u_upd (
      .cur_vec (acc_cur),
      .hit_way (acc_way),
      .nxt_vec (acc_nxt)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_sel
      logic sw_hit, hw_hit;
      assign sw_hit   = sw_go  && (sw_set  == SET_W'(s));
      assign hw_hit   = acc_go && (acc_set == SET_W'(s));
      assign wen[s]   = sw_hit | hw_hit;
      assign nxt_d[s] = sw_hit ? sw_wdata : acc_nxt;   // software has priority
   end

   lru4_set_array #(.NUM_SETS(NUM_SETS)) u_arr (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wen),
      .wr_data (nxt_d),
      .q       (cur_q)
   );

   assign rd_vec = cur_q[rd_set];

   lru4_victim_dec u_dec (
      .vec     (rd_vec),
      .victim  (victim_way),
      .illegal (victim_err)
   );

   // ---------------- assertions ----------------
   logic all_consistent;
   always_comb begin
      all_consistent = 1'b1;
      for (int s = 0; s < NUM_SETS; s++)
         if (!is_consistent(cur_q[s])) all_consistent = 1'b0;
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n || stby) |=> $stable(cur_q));

   assert_newest_R3: assert property (@(posedge clk) disable iff (!por_n)
      (acc_go && !(sw_go && sw_set == acc_set))
      |=> is_newest(cur_q[$past(acc_set)], $past(acc_way)));

   assert_sw_store_R5: assert property (@(posedge clk) disable iff (!por_n)
      sw_go |=> cur_q[$past(sw_set)] == $past(sw_wdata));

   assert_victim_oldest_R2: assert property (@(posedge clk) disable iff (!por_n)
      !victim_err |-> is_oldest(rd_vec, victim_way));

   assert_stay_legal_R9: assert property (@(posedge clk) disable iff (!por_n)
      (all_consistent && !sw_go) |=> all_consistent);
endmodule

// File: tb/sim_lru4_repl_ctrl.sv
`timescale 1ns/1ps
module sim_lru4_repl_ctrl;
   localparam int SETS = 16;
   localparam int SW   = $clog2(SETS);

   logic          clk = 1'b0;
   logic          por_n, mrst_n, stby, acc_vld, sw_we;
   logic [SW-1:0] acc_set, sw_set, rd_set;
   logic [1:0]    acc_way;
   logic [5:0]    sw_wdata, rd_vec;
   logic [1:0]    victim_way;
   logic          victim_err;

   int  checks = 0;
   int  errs   = 0;
   bit  done   = 0;
   int  ord [SETS][4];          // ord[s][0] = oldest way
   int  plo [6] = '{2, 1, 1, 0, 0, 0};
   int  phi [6] = '{3, 3, 2, 3, 2, 1};
   bit  seen [64];

   always #2.5 clk = ~clk;

   lru4_repl_ctrl #(.NUM_SETS(SETS)) u0 (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .stby(stby),
      .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
      .sw_we(sw_we), .sw_set(sw_set), .sw_wdata(sw_wdata),
      .rd_set(rd_set), .rd_vec(rd_vec), .victim_way(victim_way),
      .victim_err(victim_err));

   function automatic logic [5:0] vec_of(int o[4]);
      logic [5:0] v;
      int pos[4];
      for (int i = 0; i < 4; i++) pos[o[i]] = i;
      for (int k = 0; k < 6; k++) v[k] = (pos[plo[k]] < pos[phi[k]]);
      return v;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < SETS; s++) ord[s] = '{3, 2, 1, 0};
   endtask

   task automatic model_touch(int s, int w);
      int t[4];
      int n = 0;
      for (int i = 0; i < 4; i++) if (ord[s][i] != w) begin t[n] = ord[s][i]; n++; end
      t[3] = w;
      ord[s] = t;
   endtask

   task automatic check_set(int s, string req);
      int o[4];
      o = ord[s];
      rd_set = SW'(s);
      #1;
      chk(req, "vector", rd_vec, vec_of(o));
      chk(req, "victim", victim_way, o[0]);
      chk(req, "err", victim_err, 0);
   endtask

   task automatic drive(bit a, int as, int aw, bit w, int ws, logic [5:0] wd);
      @(negedge clk);
      acc_vld = a; acc_set = SW'(as); acc_way = 2'(aw);
      sw_we = w; sw_set = SW'(ws); sw_wdata = wd;
      @(negedge clk);
      acc_vld = 0; sw_we = 0;
   endtask

   task automatic do_access(int s, int w);
      drive(1, s, w, 0, 0, 6'd0);
      model_touch(s, w);
   endtask

   task automatic do_write(int s, int o[4]);
      drive(0, 0, 0, 1, s, vec_of(o));
      ord[s] = o;
   endtask

   task automatic rand_perm(output int o[4]);
      o = '{0, 1, 2, 3};
      for (int i = 3; i > 0; i--) begin
         int j = $urandom_range(0, i);
         int t = o[i]; o[i] = o[j]; o[j] = t;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h1A2B3C);
      por_n = 0; mrst_n = 1; stby = 0; acc_vld = 0; sw_we = 0;
      acc_set = '0; sw_set = '0; rd_set = '0; acc_way = '0; sw_wdata = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int s = 0; s < SETS; s++) begin
         rd_set = SW'(s); #1;
         chk("R1", "reset vector", rd_vec, 6'b000000);
         chk("R1", "reset victim", victim_way, 3);
         chk("R1", "reset err", victim_err, 0);
      end
      por_n = 1;
      @(negedge clk);

      // R3: directed touches
      do_access(1, 3); check_set(1, "R3");
      chk("R3", "way3 touch vector", rd_vec, 6'b001011);
      do_access(1, 0); check_set(1, "R3");
      do_access(1, 2); check_set(1, "R3");

      // R2 / R7: decode every pattern via software writes
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++)
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     int o[4];
                     o = '{a, b, c, d};
                     seen[vec_of(o)] = 1;
                     do_write(2, o);
                     check_set(2, "R2");
                  end
      for (int v = 0; v < 64; v++)
         if (!seen[v]) begin
            drive(0, 0, 0, 1, 2, 6'(v));
            rd_set = SW'(2); #1;
            chk("R5", "illegal store", rd_vec, v);
            chk("R7", "illegal victim", victim_way, 0);
            chk("R7", "illegal err", victim_err, 1);
         end
      do_write(2, '{3, 2, 1, 0});

      // R6: collisions
      begin
         int o[4];
         o = '{1, 0, 3, 2};
         drive(1, 4, 1, 1, 4, vec_of(o));
         ord[4] = o;
         check_set(4, "R6");
         o = '{2, 3, 0, 1};
         drive(1, 6, 0, 1, 5, vec_of(o));
         ord[5] = o; model_touch(6, 0);
         check_set(5, "R6"); check_set(6, "R6");
      end

      // R8: manual reset and standby block updates and keep state
      do_access(7, 3); do_access(7, 1);
      stby = 1;
      drive(1, 7, 2, 0, 0, 6'd0);
      drive(0, 0, 0, 1, 7, 6'b111111);
      stby = 0;
      check_set(7, "R8");
      mrst_n = 0;
      drive(1, 7, 2, 1, 8, 6'b111000);
      repeat (2) @(negedge clk);
      mrst_n = 1;
      check_set(7, "R8");
      check_set(8, "R8");

      // R4 / R9: random hardware accesses from a fresh power-on reset
      @(negedge clk); por_n = 0; model_reset();
      @(negedge clk); por_n = 1;
      for (int i = 0; i < 3000; i++) begin
         int s = $urandom_range(0, SETS - 1);
         do_access(s, $urandom_range(0, 3));
         check_set(s, "R4");
      end

      // R3 / R5: mixed accesses and software loads
      for (int i = 0; i < 1500; i++) begin
         int s = $urandom_range(0, SETS - 1);
         if ($urandom_range(0, 5) == 0) begin
            int o[4];
            rand_perm(o);
            do_write(s, o);
            check_set(s, "R5");
         end else begin
            do_access(s, $urandom_range(0, 3));
            check_set(s, "R3");
         end
      end

      // R1: power-on reset mid-run
      @(negedge clk); por_n = 0; model_reset();
      #1;
      for (int s = 0; s < SETS; s++) begin
         rd_set = SW'(s); #1;
         chk("R1", "por vector", rd_vec, 6'b000000);
         chk("R1", "por victim", victim_way, 3);
      end
      @(negedge clk); por_n = 1;
      @(negedge clk);
      finish_run();
   end
endmodule